// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero Bus Turnaround

This block is an on-chip synchronous static memory that presents the bus behaviour of a no-turnaround burst SRAM. A new read, write or deselect command may be issued on every rising clock edge, in any mix, with no idle cycle needed between a read and a write. Write data does not travel with its address. It arrives a fixed number of cycles later (late write), so that the data bus stays busy in both directions without a turnaround gap. Reads issued behind a write whose data has not yet landed still return the newest data.

A build-time mode parameter picks one of two variants. The pipelined variant uses a registered output and a two-cycle write-data lag. The flow-through variant has no output register and a one-cycle write-data lag. Three chip enables allow depth expansion. An advance control steps through a four-beat burst in linear or interleaved order. An asynchronous output enable can turn the read output off at any time. Data is organised as 9-bit bytes, and each byte has its own write enable.

Top module: `nbt_sram`

## Requirements
- R1: A read loaded at clock edge k drives `dout_en` high with the addressed word on `dout` after edge k+1 in pipelined mode (`PIPELINED`=1) and after edge k in flow-through mode (`PIPELINED`=0), while `oe_n` is low.
- R2: The write data for a write loaded or advanced at edge k is taken from `din` at edge k+2 in pipelined mode and at edge k+1 in flow-through mode.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns the data of the most recent write to that address issued on an earlier edge.
- R4: Byte b occupies `din`/`dout` bits [9b+8:9b]. A low `bw_n[b]` on a write's address cycle writes that byte. A high `bw_n[b]` leaves that byte of the word unchanged.
- R5: A load is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: it writes nothing and leaves `dout_en` low in the output slot where a read would have appeared.
- R6: `oe_n` high forces `dout_en` low and `dout` to zero at once, with no clock edge, and it does not disturb the pipeline.
- R7: With `lin_order`=1 at the load, beat j of a burst (j=0 at the load, then one beat per edge with `adv`=1) uses low address bits (start+j) mod 4. The upper address bits stay fixed.
- R8: With `lin_order`=0 at the load, beat j uses low address bits start XOR j.
- R9: In pipelined mode, a read loaded on the edge right after a write to the same address returns the pending write's bytes from `din`, and the bytes masked by `bw_n` come from the stored word.
- R10: Whenever `dout_en` is low, `dout` is all zeros.
- R11: An edge with `adv`=1 repeats the kind of command last loaded (read, write or deselect) and ignores the chip enables and `we`, so advancing after a deselect stays deselected.
- R12: While `rst_n` is low, and after it, until a read comes out, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of control state (not the storage) |
| addr | input | ADDR_W | Word address, used on load cycles |
| we | input | 1 | 1 = write, 0 = read, used on load cycles |
| bw_n | input | BYTES | Active-low byte write enables, sampled with each write beat's address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = advance the current burst, 0 = load a new command |
| lin_order | input | 1 | Burst order on load: 1 = linear, 0 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | BYTES*BYTE_W | Late write data |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries read data |

## Verification
The bench builds two copies side by side, one with `PIPELINED`=1 and one with `PIPELINED`=0, each with `ADDR_W`=4 and two 9-bit bytes. The 16-word space can then be filled completely, and bursts wrap inside a block of four often. Both copies receive one shared input stream, so every write's data comes from a different `din` cycle in each mode, and both lags and the pipelined forwarding path are hit many times. Directed runs of every chip-enable combination, byte-mask pattern and burst order are followed by a long pseudo-random stream. A per-edge arithmetic memory model checks every output slot of both copies.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } cmd_e;

   // low two address bits of a burst beat
   function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
      logic [1:0] r;
      if (linear) r = start + beat;
      else        r = start ^ beat;
      return r;
   endfunction

endpackage

// File: rtl/nbt_cmd_seq.sv
module nbt_cmd_seq
   import nbt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NB     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [NB-1:0]     bw_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              adv,
   input  logic              lin_order,
   output cmd_e              cmd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [NB-1:0]     cmd_be
);

   cmd_e              b_cmd;
   logic [ADDR_W-1:0] b_base;
   logic [1:0]        b_cnt;
   logic              b_lin;

   cmd_e              n_cmd;
   logic [ADDR_W-1:0] n_base;
   logic [1:0]        n_cnt;
   logic              n_lin;
   logic              selected;

   assign selected = ~ce1_n & ce2 & ~ce3_n;

   always_comb begin
      if (!adv) begin
         if (selected) n_cmd = we ? CMD_WRITE : CMD_READ;
         else          n_cmd = CMD_IDLE;
         n_base = addr;
         n_cnt  = 2'd0;
         n_lin  = lin_order;
      end else begin
         n_cmd  = b_cmd;
         n_base = b_base;
         n_cnt  = b_cnt + 2'd1;
         n_lin  = b_lin;
      end
   end

   assign cmd      = n_cmd;
   assign cmd_addr = {n_base[ADDR_W-1:2], beat_lo(n_base[1:0], n_cnt, n_lin)};
   assign cmd_be   = ~bw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_cmd  <= CMD_IDLE;
         b_base <= '0;
         b_cnt  <= 2'd0;
         b_lin  <= 1'b0;
      end else begin
         b_cmd  <= n_cmd;
         b_base <= n_base;
         b_cnt  <= n_cnt;
         b_lin  <= n_lin;
      end
   end

endmodule

// File: rtl/nbt_late_wr.sv
module nbt_late_wr #(
   parameter int ADDR_W = 8,
   parameter int NB     = 2,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NB-1:0]     wr_be,
   output logic              cm_v,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [NB-1:0]     cm_be
);

   logic [LAT-1:0]    v_q;
   logic [ADDR_W-1:0] a_q  [LAT];
   logic [NB-1:0]     be_q [LAT];

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= wr_req;
         end
         always_ff @(posedge clk) begin
            a_q[s]  <= wr_addr;
            be_q[s] <= wr_be;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= v_q[s-1];
         end
         always_ff @(posedge clk) begin
            a_q[s]  <= a_q[s-1];
            be_q[s] <= be_q[s-1];
         end
      end
   end

   assign cm_v    = v_q[LAT-1];
   assign cm_addr = a_q[LAT-1];
   assign cm_be   = be_q[LAT-1];

endmodule

// File: rtl/nbt_bank_array.sv
module nbt_bank_array #(
   parameter int ADDR_W = 8,
   parameter int NB     = 2,
   parameter int BW     = 9
) (
   input  logic              clk,
   input  logic              wr_v,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NB-1:0]     wr_be,
   input  logic [NB*BW-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NB*BW-1:0]  rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [BW-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_v && wr_be[b]) cells[wr_addr] <= wr_data[b*BW +: BW];
      end
      assign rd_data[b*BW +: BW] = cells[rd_addr];
   end

endmodule

// File: rtl/nbt_rd_out.sv
module nbt_rd_out #(
   parameter int ADDR_W = 8,
   parameter int NB     = 2,
   parameter int BW     = 9,
   parameter bit PIPE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr_in,
   input  logic              cm_v,
   input  logic [ADDR_W-1:0] cm_addr,
   input  logic [NB-1:0]     cm_be,
   input  logic [NB*BW-1:0]  wdata,
   input  logic [NB*BW-1:0]  arr_data,
   input  logic              oe_n,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [NB*BW-1:0]  dout,
   output logic              dout_en
);

   logic              r_v;
   logic [ADDR_W-1:0] r_a;
   logic [NB*BW-1:0]  merged;
   logic              hit;
   logic              o_v;
   logic [NB*BW-1:0]  o_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_v <= 1'b0;
      else        r_v <= rd_req;
   end
   always_ff @(posedge clk) r_a <= rd_addr_in;

   assign arr_addr = r_a;
   assign hit      = cm_v && (cm_addr == r_a);

   for (genvar b = 0; b < NB; b++) begin : g_fwd
      assign merged[b*BW +: BW] = (hit && cm_be[b]) ? wdata[b*BW +: BW]
                                                    : arr_data[b*BW +: BW];
   end

   if (PIPE) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) o_v <= 1'b0;
         else        o_v <= r_v;
      end
      always_ff @(posedge clk) o_d <= merged;
   end else begin : g_flow_out
      assign o_v = r_v;
      assign o_d = merged;
   end

   assign dout_en = o_v & ~oe_n;
   assign dout    = dout_en ? o_d : '0;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
   import nbt_sram_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTES     = 2,
   parameter int BYTE_W    = 9,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    we,
   input  logic [BYTES-1:0]        bw_n,
   input  logic                    ce1_n,
   input  logic                    ce2,
   input  logic                    ce3_n,
   input  logic                    adv,
   input  logic                    lin_order,
   input  logic                    oe_n,
   input  logic [BYTES*BYTE_W-1:0] din,
   output logic [BYTES*BYTE_W-1:0] dout,
   output logic                    dout_en
);

   localparam int DW     = BYTES * BYTE_W;
   localparam int WR_LAT = PIPELINED ? 2 : 1;

   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
      $error("nbt_sram: ADDR_W must lie in 3..12");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_bytes
      $error("nbt_sram: BYTES and BYTE_W must be positive");
   end

   cmd_e              cmd;
   logic [ADDR_W-1:0] cmd_addr;
   logic [BYTES-1:0]  cmd_be;
   logic              cm_v;
   logic [ADDR_W-1:0] cm_addr;
   logic [BYTES-1:0]  cm_be;
   logic [ADDR_W-1:0] arr_addr;
   logic [DW-1:0]     arr_data;

   nbt_cmd_seq #(.ADDR_W(ADDR_W), .NB(BYTES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .we        (we),
      .bw_n      (bw_n),
      .ce1_n     (ce1_n),
      .ce2       (ce2),
      .ce3_n     (ce3_n),
      .adv       (adv),
      .lin_order (lin_order),
      .cmd       (cmd),
      .cmd_addr  (cmd_addr),
      .cmd_be    (cmd_be)
   );

   nbt_late_wr #(.ADDR_W(ADDR_W), .NB(BYTES), .LAT(WR_LAT)) u_lwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (cmd == CMD_WRITE),
      .wr_addr (cmd_addr),
      .wr_be   (cmd_be),
      .cm_v    (cm_v),
      .cm_addr (cm_addr),
      .cm_be   (cm_be)
   );

   nbt_bank_array #(.ADDR_W(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_arr (
      .clk     (clk),
      .wr_v    (cm_v),
      .wr_addr (cm_addr),
      .wr_be   (cm_be),
      .wr_data (din),
      .rd_addr (arr_addr),
      .rd_data (arr_data)
   );

   nbt_rd_out #(.ADDR_W(ADDR_W), .NB(BYTES), .BW(BYTE_W), .PIPE(PIPELINED)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (cmd == CMD_READ),
      .rd_addr_in (cmd_addr),
      .cm_v       (cm_v),
      .cm_addr    (cm_addr),
      .cm_be      (cm_be),
      .wdata      (din),
      .arr_data   (arr_data),
      .oe_n       (oe_n),
      .arr_addr   (arr_addr),
      .dout       (dout),
      .dout_en    (dout_en)
   );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
   parameter bit PIPELINED = 1'b1,
   parameter int DW        = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          we,
   input logic          ce1_n,
   input logic          ce2,
   input logic          ce3_n,
   input logic          adv,
   input logic          oe_n,
   input logic [DW-1:0] dout,
   input logic          dout_en
);

   logic sel, ld_rd, ld_desel;
   assign sel      = ~ce1_n & ce2 & ~ce3_n;
   assign ld_rd    = ~adv & sel & ~we;
   assign ld_desel = ~adv & ~sel;

   if (PIPELINED) begin : g_pipe
      // R1
      rd_slot_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ld_rd, 2) && !oe_n) |-> dout_en);
      // R5
      desel_slot_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ld_desel, 2) |-> !dout_en);
      // R11
      adv_desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ld_desel, 3) && $past(adv, 2)) |-> !dout_en);
   end else begin : g_flow
      // R1
      rd_slot_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ld_rd, 1) && !oe_n) |-> dout_en);
      // R5
      desel_slot_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ld_desel, 1) |-> !dout_en);
      // R11
      adv_desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ld_desel, 2) && $past(adv, 1)) |-> !dout_en);
   end

   // R6
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dout_en && dout == '0));
   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> dout == '0);

endmodule

bind nbt_sram nbt_sram_chk #(.PIPELINED(PIPELINED), .DW(BYTES*BYTE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .we      (we),
   .ce1_n   (ce1_n),
   .ce2     (ce2),
   .ce3_n   (ce3_n),
   .adv     (adv),
   .oe_n    (oe_n),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;

   localparam int AW = 4;
   localparam int NB = 2;
   localparam int BW = 9;
   localparam int DW = NB * BW;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [NB-1:0] bw_n = '1;
   logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
   logic          adv = 1'b0, lin_order = 1'b0, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout_p, dout_f;
   logic          en_p, en_f;

   nbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .PIPELINED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .bw_n(bw_n),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv),
      .lin_order(lin_order), .oe_n(oe_n), .din(din),
      .dout(dout_p), .dout_en(en_p));

   nbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .PIPELINED(1'b0)) u_dut_ft (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .bw_n(bw_n),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv),
      .lin_order(lin_order), .oe_n(oe_n), .din(din),
      .dout(dout_f), .dout_en(en_f));

   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   string cur_req = "R12";
   logic [31:0] seed = 32'h1bad_5eed;

   // model: index 0 = flow-through, 1 = pipelined
   logic [DW-1:0] mm [2][WORDS];
   logic          b_v = 1'b0, b_we = 1'b0, b_lin = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   logic          h_rd [3] = '{1'b0, 1'b0, 1'b0};
   logic          h_wr [3] = '{1'b0, 1'b0, 1'b0};
   logic [AW-1:0] h_a  [3];
   logic [NB-1:0] h_be [3];
   logic          exp_rd [2] = '{1'b0, 1'b0};
   logic [DW-1:0] exp_val [2];

   task automatic roll(output logic [31:0] r);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      r = seed;
   endtask

   task automatic model_step();
      logic          sel, cv, cwe, lin;
      logic [AW-1:0] base, a;
      logic [1:0]    cnt, lo;
      sel = !ce1_n && ce2 && !ce3_n;
      if (!adv) begin
         cv = sel; cwe = we; base = addr; cnt = 2'd0; lin = lin_order;
      end else begin
         cv = b_v; cwe = b_we; base = b_base; cnt = b_cnt + 2'd1; lin = b_lin;
      end
      lo = lin ? (base[1:0] + cnt) : (base[1:0] ^ cnt);
      a  = {base[AW-1:2], lo};
      b_v = cv; b_we = cwe; b_base = base; b_cnt = cnt; b_lin = lin;
      for (int i = 2; i > 0; i--) begin
         h_rd[i] = h_rd[i-1]; h_wr[i] = h_wr[i-1];
         h_a[i]  = h_a[i-1];  h_be[i] = h_be[i-1];
      end
      h_rd[0] = cv && !cwe; h_wr[0] = cv && cwe; h_a[0] = a; h_be[0] = ~bw_n;
      for (int m = 0; m < 2; m++) begin
         int lag;
         lag = m + 1;
         if (h_wr[lag])
            for (int b = 0; b < NB; b++)
               if (h_be[lag][b]) mm[m][h_a[lag]][b*BW +: BW] = din[b*BW +: BW];
      end
      exp_rd[0] = h_rd[0]; exp_val[0] = mm[0][h_a[0]];
      exp_rd[1] = h_rd[1]; exp_val[1] = mm[1][h_a[1]];
   endtask

   task automatic check_dut(input string nm, input logic en, input logic [DW-1:0] d,
                            input int m);
      logic          e_en;
      logic [DW-1:0] e_d;
      e_en = exp_rd[m] && !oe_n;
      e_d  = e_en ? exp_val[m] : '0;
      checks++;
      if (en !== e_en) begin
         errors++;
         $display("FAIL %s %s dout_en actual=%b expected=%b", cur_req, nm, en, e_en);
      end
      checks++;
      if (d !== e_d) begin
         errors++;
         $display("FAIL %s %s dout actual=%h expected=%h",
                  e_en ? cur_req : "R10", nm, d, e_d);
      end
   endtask

   // one clock: drive at negedge, check the previous slot, advance the model
   task automatic cyc(input bit ldc, input bit wec, input logic [AW-1:0] a,
                      input logic [1:0] bwn, input logic [2:0] cb,
                      input bit lin, input bit oen);
      logic [31:0] r;
      roll(r);
      @(negedge clk);
      adv = !ldc; we = wec; addr = a; bw_n = bwn;
      ce1_n = cb[0]; ce2 = !cb[1]; ce3_n = cb[2];
      lin_order = lin; oe_n = oen; din = r[DW-1:0];
      #5;
      check_dut("pipe", en_p, dout_p, 1);
      check_dut("flow", en_f, dout_f, 0);
      model_step();
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [1:0] bwn);
      cyc(1'b1, 1'b1, a, bwn, 3'b000, 1'b1, 1'b0);
   endtask
   task automatic rd(input logic [AW-1:0] a);
      cyc(1'b1, 1'b0, a, 2'b11, 3'b000, 1'b1, 1'b0);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 2'b11, 3'b001, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      cur_req = "R12";
      checks++;
      if (en_p !== 1'b0) begin errors++; $display("FAIL R12 pipe dout_en actual=%b expected=0", en_p); end
      checks++;
      if (en_f !== 1'b0) begin errors++; $display("FAIL R12 flow dout_en actual=%b expected=0", en_f); end
      rst_n = 1'b1;
      idle(2);

      cur_req = "R2";                       // fill every word, back to back
      for (int a = 0; a < WORDS; a++) wr(a[AW-1:0], 2'b00);
      idle(3);

      cur_req = "R1";
      for (int a = 0; a < 6; a++) rd(a[AW-1:0]);
      idle(3);

      cur_req = "R9";                       // read right behind a masked write
      wr(4'd5, 2'b10); rd(4'd5);
      wr(4'd6, 2'b01); rd(4'd6); rd(4'd6);
      wr(4'd7, 2'b00); rd(4'd7); wr(4'd7, 2'b10); rd(4'd7);
      idle(3);

      cur_req = "R3";                       // read/write alternation, no gaps
      for (int i = 0; i < 8; i++) begin
         wr(i[AW-1:0], 2'b00);
         rd(4'(i ^ 1));
      end
      idle(3);

      cur_req = "R4";
      wr(4'd8, 2'b01); wr(4'd9, 2'b10); wr(4'd10, 2'b11); wr(4'd11, 2'b00);
      idle(3);
      rd(4'd8); rd(4'd9); rd(4'd10); rd(4'd11);
      idle(3);

      cur_req = "R5";                       // each chip enable off in turn
      for (int k = 0; k < 3; k++) begin
         logic [2:0] cbv;
         cbv = 3'b001 << k;
         cyc(1'b1, 1'b1, 4'd3, 2'b00, cbv, 1'b0, 1'b0);
         cyc(1'b1, 1'b0, 4'd3, 2'b11, cbv, 1'b0, 1'b0);
         idle(3);
         rd(4'd3);
         idle(3);
      end

      cur_req = "R6";
      rd(4'd1);
      cyc(1'b1, 1'b0, 4'd2, 2'b11, 3'b000, 1'b1, 1'b1);
      cyc(1'b1, 1'b0, 4'd4, 2'b11, 3'b000, 1'b1, 1'b1);
      cyc(1'b1, 1'b0, 4'd8, 2'b11, 3'b000, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 4'd9, 2'b11, 3'b001, 1'b1, 1'b1);
      idle(3);

      cur_req = "R7";                       // linear bursts
      cyc(1'b1, 1'b0, 4'd6, 2'b11, 3'b000, 1'b1, 1'b0);
      for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, '0, 2'b11, 3'b000, 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 4'd13, 2'b00, 3'b000, 1'b1, 1'b0);
      for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, '0, 2'(j), 3'b000, 1'b0, 1'b0);
      idle(2);
      for (int a = 12; a < 16; a++) rd(a[AW-1:0]);
      idle(3);

      cur_req = "R8";                       // interleaved bursts
      cyc(1'b1, 1'b0, 4'd3, 2'b11, 3'b000, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, '0, 2'b11, 3'b000, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 4'd9, 2'b00, 3'b000, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, '0, 2'b00, 3'b000, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 4'd10, 2'b11, 3'b000, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) cyc(1'b0, 1'b0, '0, 2'b11, 3'b000, 1'b1, 1'b0);
      idle(3);

      cur_req = "R11";                      // advance keeps the loaded kind
      cyc(1'b1, 1'b0, 4'd2, 2'b11, 3'b010, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 4'd2, 2'b00, 3'b000, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 4'd2, 2'b00, 3'b000, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 4'd4, 2'b11, 3'b000, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 4'd0, 2'b00, 3'b111, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 4'd0, 2'b00, 3'b101, 1'b0, 1'b0);
      idle(3);
      for (int a = 0; a < 8; a++) rd(a[AW-1:0]);
      idle(3);

      cur_req = "R3";                       // long mixed stream
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] r;
         logic [2:0]  cb;
         roll(r);
         cb = (r[11:9] == 3'd0) ? r[14:12] : 3'b000;
         cyc(r[0] | r[1], r[2], r[6:3], r[8:7], cb, r[18], r[15] & r[16] & r[17]);
      end
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule